// File: doc/BRIEF.md
# Embedded Video Sync Decoder

This block watches an 8-bit digital video byte stream that carries its timing as in-band reference codes instead of on dedicated pins. Each code is the preamble 0xFF, 0x00, 0x00 followed by a status byte. The block recognises these codes, checks them, and turns them into a horizontal sync pulse, a vertical blanking level and a field flag. A capture stage downstream can then treat the stream as if it had discrete sync wires. A byte enable qualifies every byte, so the stream may run slower than the clock.

The horizontal pulse marks the start of active video on every line. The vertical level spans the whole vertical blanking interval. The field flag is taken only when vertical blanking begins, so it stays constant for a complete field and software can tell the two interlaced fields apart. Both sync outputs have a run-time polarity control, applied after the pulses are formed. For this embedded mode both would normally be set to active-low, so that the first pixel seen internally is the first active pixel.

Malformed status bytes are discarded and counted. A lock flag reports whether the vertical codes have been arriving in a consistent alternating-field order. The flag drops when valid codes stop for a programmable number of line periods.

Top module: `emb_sync_decoder`

## Requirements
- R1: A status byte is examined only when it follows the three enabled bytes 0xFF, 0x00, 0x00 in that order. An 0xFF received partway through a preamble starts a new preamble, so FF FF 00 00 XY is a valid code. Any other byte breaks the match.
- R2: Status byte layout is bit7 = 1, bit6 = F, bit5 = V, bit4 = H, and bits 3..0 = {V^H, F^H, F^V, F^V^H}. A status byte with bit7 = 0 or with wrong protection bits is ignored: it produces no horizontal pulse and no vertical or field change.
- R3: A valid status byte with H = 0 (start of active video) drives the internal horizontal pulse high in exactly the cycle the byte is presented with its enable. `hsync_o` equals that pulse XOR `hs_invert_i`.
- R4: The internal vertical level rises in the cycle of a valid status byte with V = 1 while it is low. It stays high across any other codes, including V = 0 end-of-active codes. It falls in the cycle of a valid status byte with V = 0 and H = 0. `vsync_o` equals that level XOR `vs_invert_i`.
- R5: `field_o` takes the F bit of the status byte that raised the vertical level, from the following cycle. F bits in all other codes have no effect on it.
- R6: `code_err_cnt_o` increases by one in the cycle after each invalid status byte and saturates at 2^ERR_W-1.
- R7: A vertical-blanking start (a rise of the vertical level) whose F differs from the previous one extends a run. A start with the same F restarts the run at 1 and clears `locked_o`. `locked_o` rises in the cycle after the run reaches LOCK_FIELDS (default 4, that is two frames).
- R8: With `lock_timeout_lines_i` = N > 0, `locked_o` falls, and the run restarts from zero, once N*LINE_BYTES enabled bytes have passed with no valid status byte. N = 0 disables the timeout.
- R9: After reset the internal pulse and level are low, `field_o` = 0, `code_err_cnt_o` = 0 and `locked_o` = 0.
- R10: Cycles with `byte_en_i` low change no state, whatever `byte_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_en_i | input | 1 | Qualifies `byte_i` in this cycle |
| byte_i | input | 8 | Video stream byte |
| hs_invert_i | input | 1 | 1 makes `hsync_o` active-low |
| vs_invert_i | input | 1 | 1 makes `vsync_o` active-low |
| lock_timeout_lines_i | input | LINE_CNT_W | Line periods without a valid code before lock is lost; 0 disables |
| hsync_o | output | 1 | Horizontal start-of-active pulse after polarity |
| vsync_o | output | 1 | Vertical blanking level after polarity |
| field_o | output | 1 | Field of the current vertical interval |
| code_err_cnt_o | output | ERR_W | Saturating count of rejected status bytes |
| locked_o | output | 1 | Consistent vertical code sequence seen |

## Verification
A start-of-active code with V = 1 that arrives while the vertical level is low fires the horizontal pulse and raises the vertical level in the same cycle, and it also schedules a field update for the next cycle. The bench provokes this by sending such a code right after a field's first active line. It captures both sync outputs while the status byte is still on the input, then checks the new field flag one cycle later. The symmetric case is also covered: a start-of-active code with V = 0 pulses the horizontal output in the very cycle the vertical level drops. It is judged the same way, and again under inverted polarity.

// File: rtl/esd_pkg.sv
package esd_pkg;

   typedef enum logic [1:0] {
      PM_IDLE,
      PM_GOT_FF,
      PM_GOT_FF00,
      PM_AT_HDR
   } pm_state_t;

   typedef struct packed {
      logic f;
      logic v;
      logic h;
   } sync_flags_t;

   function automatic logic [3:0] prot_bits(input sync_flags_t fl);
      return {fl.v ^ fl.h, fl.f ^ fl.h, fl.f ^ fl.v, fl.f ^ fl.v ^ fl.h};
   endfunction

endpackage

// File: rtl/esd_preamble_match.sv
module esd_preamble_match
   import esd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       byte_en_i,
   input  logic [7:0] byte_i,
   output logic       status_cycle_o
);

   pm_state_t state_q, state_n;

   always_comb begin
      state_n = state_q;
      if (byte_en_i) begin
         unique case (state_q)
            PM_IDLE:     state_n = (byte_i == 8'hFF) ? PM_GOT_FF : PM_IDLE;
            PM_GOT_FF:   state_n = (byte_i == 8'h00) ? PM_GOT_FF00 :
                                   (byte_i == 8'hFF) ? PM_GOT_FF : PM_IDLE;
            PM_GOT_FF00: state_n = (byte_i == 8'h00) ? PM_AT_HDR :
                                   (byte_i == 8'hFF) ? PM_GOT_FF : PM_IDLE;
            PM_AT_HDR:   state_n = (byte_i == 8'hFF) ? PM_GOT_FF : PM_IDLE;
            default:     state_n = PM_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PM_IDLE;
      else        state_q <= state_n;
   end

   assign status_cycle_o = byte_en_i && (state_q == PM_AT_HDR);

   // R10: a disabled cycle leaves the matcher where it was
   assert_gap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_en_i |=> $stable(state_q));

endmodule

// File: rtl/esd_status_check.sv
module esd_status_check
   import esd_pkg::*;
#(
   parameter int ERR_W      = 8,
   parameter bit CHECK_PROT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        status_cycle_i,
   input  logic [7:0]  byte_i,
   output logic        code_ok_o,
   output sync_flags_t flags_o,
   output logic [ERR_W-1:0] err_cnt_o
);

   localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

   initial begin
      assert (ERR_W >= 1 && ERR_W <= 32) else $fatal(1, "ERR_W out of range");
   end

   logic prot_ok;
   logic bad_byte;
   logic [ERR_W-1:0] err_q;

   assign flags_o = '{f: byte_i[6], v: byte_i[5], h: byte_i[4]};

   generate
      if (CHECK_PROT) begin : g_strict
         assign prot_ok = (byte_i[3:0] == prot_bits(flags_o));
      end else begin : g_loose
         assign prot_ok = 1'b1;
      end
   endgenerate

   assign bad_byte  = status_cycle_i && !(byte_i[7] && prot_ok);
   assign code_ok_o = status_cycle_i && !bad_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           err_q <= '0;
      else if (bad_byte && err_q != ERR_MAX) err_q <= err_q + 1'b1;
   end

   assign err_cnt_o = err_q;

   assert_err_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q == ERR_MAX) |=> (err_q == ERR_MAX));

endmodule

// File: rtl/esd_timing_gen.sv
module esd_timing_gen
   import esd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        code_ok_i,
   input  sync_flags_t flags_i,
   input  logic        hs_invert_i,
   input  logic        vs_invert_i,
   output logic        hsync_o,
   output logic        vsync_o,
   output logic        field_o,
   output logic        vs_set_o
);

   logic vs_q, field_q;
   logic vs_set, vs_clr, vs_int, hs_int;

   assign vs_set = code_ok_i && flags_i.v && !vs_q;
   assign vs_clr = code_ok_i && !flags_i.v && !flags_i.h && vs_q;
   assign vs_int = vs_set || (vs_q && !vs_clr);
   assign hs_int = code_ok_i && !flags_i.h;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_q    <= 1'b0;
         field_q <= 1'b0;
      end else begin
         vs_q <= vs_int;
         if (vs_set) field_q <= flags_i.f;
      end
   end

   assign hsync_o  = hs_int ^ hs_invert_i;
   assign vsync_o  = vs_int ^ vs_invert_i;
   assign field_o  = field_q;
   assign vs_set_o = vs_set;

   assert_hs_from_sav_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hsync_o ^ hs_invert_i) |-> (code_ok_i && !flags_i.h));

   assert_vs_fall_on_sav_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vs_q) |-> $past(code_ok_i && !flags_i.v && !flags_i.h));

   assert_field_only_at_vbl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(field_q) |-> $rose(vs_q));

endmodule

// File: rtl/esd_lock_monitor.sv
module esd_lock_monitor #(
   parameter int LOCK_FIELDS = 4,
   parameter int LINE_BYTES  = 1716,
   parameter int LINE_CNT_W  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  byte_en_i,
   input  logic                  code_ok_i,
   input  logic                  vs_set_i,
   input  logic                  f_new_i,
   input  logic                  f_prev_i,
   input  logic [LINE_CNT_W-1:0] tmo_lines_i,
   output logic                  locked_o
);

   localparam int RUN_W  = $clog2(LOCK_FIELDS + 1);
   localparam int BYTE_W = $clog2(LINE_BYTES);
   localparam logic [BYTE_W-1:0]     LAST_BYTE = BYTE_W'(LINE_BYTES - 1);
   localparam logic [RUN_W-1:0]      RUN_TOP   = RUN_W'(LOCK_FIELDS);
   localparam logic [LINE_CNT_W-1:0] LINES_MAX = {LINE_CNT_W{1'b1}};

   initial begin
      assert (LOCK_FIELDS >= 1) else $fatal(1, "LOCK_FIELDS must be positive");
      assert (LINE_BYTES >= 2)  else $fatal(1, "LINE_BYTES must be at least 2");
      assert (LINE_CNT_W >= 1)  else $fatal(1, "LINE_CNT_W must be positive");
   end

   logic [BYTE_W-1:0]     bytes_q, bytes_n;
   logic [LINE_CNT_W-1:0] lines_q, lines_n;
   logic [RUN_W-1:0]      run_q, run_n;
   logic                  locked_q, locked_n;
   logic                  tmo_hit;

   always_comb begin
      bytes_n = bytes_q;
      lines_n = lines_q;
      if (code_ok_i) begin
         bytes_n = '0;
         lines_n = '0;
      end else if (byte_en_i) begin
         if (bytes_q == LAST_BYTE) begin
            bytes_n = '0;
            if (lines_q != LINES_MAX) lines_n = lines_q + 1'b1;
         end else begin
            bytes_n = bytes_q + 1'b1;
         end
      end
   end

   assign tmo_hit = (tmo_lines_i != '0) && (lines_n >= tmo_lines_i);

   always_comb begin
      run_n    = run_q;
      locked_n = locked_q;
      if (tmo_hit) begin
         run_n    = '0;
         locked_n = 1'b0;
      end else if (vs_set_i) begin
         if (run_q == '0 || f_new_i != f_prev_i) begin
            run_n = (run_q == RUN_TOP) ? run_q : run_q + 1'b1;
         end else begin
            run_n    = RUN_W'(1);
            locked_n = 1'b0;
         end
         if (run_n >= RUN_TOP) locked_n = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bytes_q  <= '0;
         lines_q  <= '0;
         run_q    <= '0;
         locked_q <= 1'b0;
      end else begin
         bytes_q  <= bytes_n;
         lines_q  <= lines_n;
         run_q    <= run_n;
         locked_q <= locked_n;
      end
   end

   assign locked_o = locked_q;

   assert_lock_rise_at_vbl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_q) |-> $past(vs_set_i));

   assert_lock_fall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked_q) |-> $past(vs_set_i || (tmo_lines_i != '0 && !code_ok_i)));

endmodule

// File: rtl/emb_sync_decoder.sv
module emb_sync_decoder
   import esd_pkg::*;
#(
   parameter int ERR_W       = 8,
   parameter int LOCK_FIELDS = 4,
   parameter int LINE_BYTES  = 1716,
   parameter int LINE_CNT_W  = 8,
   parameter bit CHECK_PROT  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  byte_en_i,
   input  logic [7:0]            byte_i,
   input  logic                  hs_invert_i,
   input  logic                  vs_invert_i,
   input  logic [LINE_CNT_W-1:0] lock_timeout_lines_i,
   output logic                  hsync_o,
   output logic                  vsync_o,
   output logic                  field_o,
   output logic [ERR_W-1:0]      code_err_cnt_o,
   output logic                  locked_o
);

   logic        status_cycle;
   logic        code_ok;
   sync_flags_t flags;
   logic        vs_set;
   logic        field_cur;

   esd_preamble_match u_match (
      .clk            (clk),
      .rst_n          (rst_n),
      .byte_en_i      (byte_en_i),
      .byte_i         (byte_i),
      .status_cycle_o (status_cycle)
   );

   esd_status_check #(
      .ERR_W      (ERR_W),
      .CHECK_PROT (CHECK_PROT)
   ) u_check (
      .clk            (clk),
      .rst_n          (rst_n),
      .status_cycle_i (status_cycle),
      .byte_i         (byte_i),
      .code_ok_o      (code_ok),
      .flags_o        (flags),
      .err_cnt_o      (code_err_cnt_o)
   );

   esd_timing_gen u_timing (
      .clk         (clk),
      .rst_n       (rst_n),
      .code_ok_i   (code_ok),
      .flags_i     (flags),
      .hs_invert_i (hs_invert_i),
      .vs_invert_i (vs_invert_i),
      .hsync_o     (hsync_o),
      .vsync_o     (vsync_o),
      .field_o     (field_cur),
      .vs_set_o    (vs_set)
   );

   esd_lock_monitor #(
      .LOCK_FIELDS (LOCK_FIELDS),
      .LINE_BYTES  (LINE_BYTES),
      .LINE_CNT_W  (LINE_CNT_W)
   ) u_lock (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_en_i   (byte_en_i),
      .code_ok_i   (code_ok),
      .vs_set_i    (vs_set),
      .f_new_i     (flags.f),
      .f_prev_i    (field_cur),
      .tmo_lines_i (lock_timeout_lines_i),
      .locked_o    (locked_o)
   );

   assign field_o = field_cur;

endmodule

// File: tb/test_emb_sync_decoder.sv
`timescale 1ns/1ps
module test_emb_sync_decoder;

   localparam int ERR_W = 4;
   localparam int LINE_BYTES = 16;
   localparam int LINE_CNT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic byte_en = 1'b0;
   logic [7:0] byte_d = 8'h10;
   logic hs_inv = 1'b0, vs_inv = 1'b0;
   logic [LINE_CNT_W-1:0] tmo = '0;
   logic hsync, vsync, field;
   logic [ERR_W-1:0] errc;
   logic locked;

   int checks = 0, fails = 0;
   logic s_hs, s_vs;
   bit done = 0;

   always #4 clk = ~clk;

   emb_sync_decoder #(.ERR_W(ERR_W), .LOCK_FIELDS(4), .LINE_BYTES(LINE_BYTES),
                      .LINE_CNT_W(LINE_CNT_W), .CHECK_PROT(1'b1)) i_emb_sync_decoder (
      .clk(clk), .rst_n(rst_n), .byte_en_i(byte_en), .byte_i(byte_d),
      .hs_invert_i(hs_inv), .vs_invert_i(vs_inv), .lock_timeout_lines_i(tmo),
      .hsync_o(hsync), .vsync_o(vsync), .field_o(field),
      .code_err_cnt_o(errc), .locked_o(locked));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] mk(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      byte_d = b; byte_en = 1'b1;
      #1; s_hs = hsync; s_vs = vsync;
   endtask

   task automatic gap(input logic [7:0] junk);
      @(negedge clk);
      byte_d = junk; byte_en = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk);
      byte_en = 1'b0; byte_d = 8'h10;
      #1;
   endtask

   task automatic code(input logic f, input logic v, input logic h);
      put(8'hFF); put(8'h00); put(8'h00); put(mk(f, v, h));
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; byte_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
   endtask

   task automatic t_reset();
      do_reset();
      chk("R9 hsync", hsync, 0); chk("R9 vsync", vsync, 0);
      chk("R9 field", field, 0); chk("R9 err", errc, 0); chk("R9 locked", locked, 0);
   endtask

   task automatic t_hsync();
      code(0, 0, 0); chk("R3 sav pulse", s_hs, 1);
      settle(); chk("R3 pulse ends", hsync, 0);
      code(0, 0, 1); chk("R3 eav no pulse", s_hs, 0);
      settle();
   endtask

   task automatic t_preamble();
      put(8'hFF); put(8'hFF); put(8'h00); put(8'h00); put(mk(0, 0, 0));
      chk("R1 ff restart", s_hs, 1);
      put(8'hFF); put(8'h00); put(8'hAA); put(8'h00); put(mk(0, 0, 0));
      chk("R1 broken preamble", s_hs, 0);
      put(8'hFF); gap(8'h33); put(8'h00); gap(8'hFF); put(8'h00); gap(8'h55);
      put(mk(0, 0, 0));
      chk("R10 gaps ignored", s_hs, 1);
      settle();
      chk("R1 no error", errc, 0);
   endtask

   task automatic t_invalid();
      code(0, 0, 0);
      put(8'hFF); put(8'h00); put(8'h00); put(mk(0, 1, 0) ^ 8'h01);
      chk("R2 bad prot no hs", s_hs, 0); chk("R2 bad prot no vs", s_vs, 0);
      settle(); chk("R6 err 1", errc, 1);
      put(8'hFF); put(8'h00); put(8'h00); put(8'h50);
      chk("R2 bit7 low no hs", s_hs, 0);
      settle(); chk("R6 err 2", errc, 2); chk("R2 field untouched", field, 0);
   endtask

   task automatic t_vertical();
      code(1, 1, 1); chk("R4 vs rise", s_vs, 1); chk("R3 eav no hs", s_hs, 0);
      settle(); chk("R5 field 1", field, 1); chk("R4 vs held", vsync, 1);
      code(1, 1, 0); chk("R4 vs through sav", s_vs, 1);
      code(0, 1, 1); settle(); chk("R5 F ignored mid-blank", field, 1);
      code(1, 0, 1); chk("R4 eav keeps vs", s_vs, 1);
      code(1, 0, 0); chk("R4 vs falls at sav", s_vs, 0); chk("R3 hs at fall", s_hs, 1);
      settle(); chk("R5 field kept", field, 1);
      // same-cycle case: start of active with V=1 while vertical low
      code(0, 1, 0); chk("R3 hs same cycle", s_hs, 1); chk("R4 vs same cycle", s_vs, 1);
      settle(); chk("R5 field next cycle", field, 0); chk("R4 vs high", vsync, 1);
   endtask

   task automatic t_polarity();
      hs_inv = 1'b1; vs_inv = 1'b1;
      settle(); chk("R3 inverted idle", hsync, 1); chk("R4 inverted blank", vsync, 0);
      code(0, 0, 0); chk("R3 inverted pulse", s_hs, 0); chk("R4 inverted active", s_vs, 1);
      hs_inv = 1'b0; vs_inv = 1'b0;
      settle();
   endtask

   task automatic t_err_sat();
      for (int i = 0; i < 13; i++) begin
         put(8'hFF); put(8'h00); put(8'h00); put(8'h81);
      end
      settle(); chk("R6 err 15", errc, 15);
      put(8'hFF); put(8'h00); put(8'h00); put(8'h81);
      settle(); chk("R6 saturated", errc, 15);
   endtask

   task automatic field_pair(input logic f);
      code(f, 1, 1); code(f, 0, 0);
   endtask

   task automatic t_lock();
      do_reset();
      tmo = '0;
      field_pair(0); field_pair(1); field_pair(0); settle();
      chk("R7 not yet locked", locked, 0);
      field_pair(1); settle(); chk("R7 locked", locked, 1);
      field_pair(1); settle(); chk("R7 repeat field unlocks", locked, 0);
      field_pair(0); field_pair(1); settle(); chk("R7 run 3 unlocked", locked, 0);
      field_pair(0); settle(); chk("R7 relocked", locked, 1);
   endtask

   task automatic t_timeout();
      for (int i = 0; i < 100; i++) put(8'h10);
      settle(); chk("R8 disabled timeout", locked, 1);
      code(0, 0, 1);
      tmo = 8'd2;
      settle();
      for (int i = 0; i < 2 * LINE_BYTES - 1; i++) put(8'h10);
      settle(); chk("R8 before limit", locked, 1);
      put(8'h10);
      settle(); chk("R8 at limit", locked, 0);
      tmo = '0;
      field_pair(1); field_pair(0); field_pair(1); settle();
      chk("R8 run restarted", locked, 0);
      field_pair(0); settle(); chk("R8 relock after restart", locked, 1);
   endtask

   initial begin
      t_reset();
      t_hsync();
      t_preamble();
      t_invalid();
      t_vertical();
      t_polarity();
      t_err_sat();
      t_lock();
      t_timeout();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule